// File: doc/BRIEF.md
# Timer Compare Register Access Decoder

This block judges every read or write aimed at the timer compare registers. It takes a system-register encoding of five fields (op0, op1, CRn, CRm, op2), the access direction and a set of control inputs. The control inputs are the current privilege level from 0 to 3, the security state, whether secure level 2 is implemented and enabled, the host-mode and trap-general bits, the three-bit nested-virtualisation field, and four timer access-enable bits. From these it returns one registered verdict. The verdict is one of four outcomes: no match, undefined, trap (with a target level and a syndrome class), or granted (with a storage selector).

Two encodings are recognised. The first is the dedicated secure-hypervisor compare register. The second is the shared level-0 physical compare alias, which resolves to one of three physical compare registers or to a memory slot, depending on the level, host mode, security state and nested-virtualisation bits. Where several rules apply, they are evaluated in a fixed priority order and the first match decides. The register storage and the trap handling are left to the surrounding logic.

Top module: `tmrcmp_access_decoder`

## Requirements
- R1: The secure-hypervisor register is hit by op0=3, op1=4, CRn=14, CRm=5, op2=2, and the alias by op0=3, op1=3, CRn=14, CRm=2, op2=2. Any other encoding yields result code 0 (no match).
- R2: For the secure-hypervisor register, the result is undefined (code 1) when secure level 2 is not implemented, and also for any access from level 0.
- R3: For the secure-hypervisor register at level 1, the result is undefined in non-secure state. In secure state, bit 0 of the nested-virtualisation field set gives a trap (code 2) to level 2. Otherwise the result is undefined.
- R4: For the secure-hypervisor register, the result is granted (code 3) with selector 1 (secure hypervisor) at level 2 in secure state and at level 3 with the secure-level-2 enable set. Every other case at those levels is undefined.
- R5: For the alias at level 0, with level-0 host mode meaning host mode AND trap-general, the trap rules are checked in this order, and each trap goes to level 2 unless stated otherwise. (a) Not in level-0 host mode and the kernel level-0 timer bit clear: the target is level 2 if level 2 is enabled and trap-general is set, else level 1. (b) Level 2 enabled, not host mode, and the level-1 counter bit clear. (c) Host mode, trap-general clear, and the level-1 timer bit clear. (d) In level-0 host mode and the hypervisor level-0 timer bit clear.
- R6: For the alias at level 0 with no trap, the access is granted. In level-0 host mode, the selector is 1 when secure with secure level 2 implemented, and 2 (non-secure hypervisor) when non-secure. In every other case the selector is 3 (level-0 physical).
- R7: For the alias at level 1, the access traps to level 2 in two cases: level 2 is enabled, not in host mode, with the level-1 counter bit clear; or host mode is set with the level-1 timer bit clear. Otherwise, a nested-virtualisation field of 3'b111 grants selector 4 (memory) with offset 0x178, and any other value grants selector 3.
- R8: For the alias at level 2, the access is granted. In host mode, the selector is 1 when secure with secure level 2 implemented, and 2 when non-secure. In every other case the selector is 3.
- R9: For the alias at level 3, the access is always granted with selector 3.
- R10: Outputs are registered with one cycle of latency. Reset gives code 0, selector 0, trap level 0, class 0 and offset 0. A trap reports class 0x18. The class output is 0 unless the result is a trap, and the offset output is 0 unless the selector is 4.
- R11: The access direction has no effect on the verdict, and it is echoed on the direction output with the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_op0_i | input | 2 | Encoding field op0 |
| enc_op1_i | input | 3 | Encoding field op1 |
| enc_crn_i | input | 4 | Encoding field CRn |
| enc_crm_i | input | 4 | Encoding field CRm |
| enc_op2_i | input | 3 | Encoding field op2 |
| wr_i | input | 1 | 1 = write, 0 = read |
| el_i | input | 2 | Current privilege level |
| secure_i | input | 1 | Secure state |
| sel2_impl_i | input | 1 | Secure level 2 implemented |
| sel2_en_i | input | 1 | Secure level 2 enabled (from level 3 control) |
| el2_en_i | input | 1 | Level 2 enabled in the current state |
| host_el2_i | input | 1 | Level 2 runs in host mode |
| tge_i | input | 1 | Trap-general-exceptions bit |
| nv_i | input | 3 | Effective nested-virtualisation field |
| kctl_el0_ten_i | input | 1 | Kernel control: level-0 timer access |
| hctl_el1_pcen_i | input | 1 | Hypervisor control: level-1 counter access |
| hctl_el1_ten_i | input | 1 | Hypervisor control: level-1 timer access |
| hctl_el0_ten_i | input | 1 | Hypervisor control: level-0 timer access |
| res_o | output | 2 | 0 no match, 1 undefined, 2 trap, 3 granted |
| sel_o | output | 3 | 0 none, 1 secure hyp, 2 non-secure hyp, 3 level-0 physical, 4 memory |
| trap_el_o | output | 2 | Trap target level (0 when not a trap) |
| trap_class_o | output | SYND_W | Syndrome class of a trap |
| mem_off_o | output | OFF_W | Memory slot offset when the selector is 4 |
| wr_o | output | 1 | Registered access direction |

## Verification
The bench uses the default parameters: 6-bit class, 12-bit offset, and the two encodings given in R1. With these, all fifteen control bits (level, security, feature and enable bits, host mode, trap-general, the three nested-virtualisation bits and the four access bits) can be swept exhaustively for each of the two recognised encodings, about sixty-five thousand vectors, so every branch of the trap priority order and every selector is reached. The direction input is folded into the sweep as the parity of the vector, and a handful of one-field-off encodings cover the no-match path.

// File: rtl/tmrcmp_pkg.sv
package tmrcmp_pkg;

  typedef enum logic [1:0] {
    RES_NOMATCH = 2'd0,
    RES_UNDEF   = 2'd1,
    RES_TRAP    = 2'd2,
    RES_GRANT   = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    SEL_NONE     = 3'd0,
    SEL_SEC_HYP  = 3'd1,
    SEL_NS_HYP   = 3'd2,
    SEL_EL0_PHYS = 3'd3,
    SEL_MEM      = 3'd4
  } sel_e;

  typedef struct packed {
    res_e       res;
    sel_e       sel;
    logic [1:0] tgt_el;
  } verdict_t;

endpackage

// File: rtl/tmrcmp_enc_match.sv
module tmrcmp_enc_match #(
  parameter logic [1:0] OP0 = 2'd3,
  parameter logic [2:0] OP1 = 3'd3,
  parameter logic [3:0] CRN = 4'd14,
  parameter logic [3:0] CRM = 4'd2,
  parameter logic [2:0] OP2 = 3'd2
) (
  input  logic [1:0] op0_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  output logic       hit_o
);
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY = {OP0, OP1, CRN, CRM, OP2};

  logic [KEY_W-1:0] key_in;
  assign key_in = {op0_i, op1_i, crn_i, crm_i, op2_i};
  assign hit_o  = (key_in == KEY);
endmodule

// File: rtl/tmrcmp_sechyp_rules.sv
module tmrcmp_sechyp_rules
  import tmrcmp_pkg::*;
(
  input  logic [1:0] el_i,
  input  logic       secure_i,
  input  logic       sel2_impl_i,
  input  logic       sel2_en_i,
  input  logic       nv0_i,
  output verdict_t   v_o
);
  always_comb begin
    v_o = '{res: RES_UNDEF, sel: SEL_NONE, tgt_el: 2'd0};
    if (sel2_impl_i) begin
      unique case (el_i)
        2'd0: ;
        2'd1: if (secure_i && nv0_i)
                v_o = '{res: RES_TRAP, sel: SEL_NONE, tgt_el: 2'd2};
        2'd2: if (secure_i)
                v_o = '{res: RES_GRANT, sel: SEL_SEC_HYP, tgt_el: 2'd0};
        default: if (sel2_en_i)
                v_o = '{res: RES_GRANT, sel: SEL_SEC_HYP, tgt_el: 2'd0};
      endcase
    end
  end
endmodule

// File: rtl/tmrcmp_alias_rules.sv
module tmrcmp_alias_rules
  import tmrcmp_pkg::*;
(
  input  logic [1:0] el_i,
  input  logic       secure_i,
  input  logic       sel2_impl_i,
  input  logic       el2_en_i,
  input  logic       host_el2_i,
  input  logic       tge_i,
  input  logic [2:0] nv_i,
  input  logic       kctl_el0_ten_i,
  input  logic       hctl_el1_pcen_i,
  input  logic       hctl_el1_ten_i,
  input  logic       hctl_el0_ten_i,
  output verdict_t   v_o
);
  logic host_el0;
  sel_e host_sel;

  assign host_el0 = host_el2_i & tge_i;

  // Selector used when host mode routes the alias to a hypervisor register
  always_comb begin
    if (secure_i && sel2_impl_i) host_sel = SEL_SEC_HYP;
    else if (!secure_i)          host_sel = SEL_NS_HYP;
    else                         host_sel = SEL_EL0_PHYS;
  end

  always_comb begin
    v_o = '{res: RES_GRANT, sel: SEL_EL0_PHYS, tgt_el: 2'd0};
    unique case (el_i)
      2'd0: begin
        if (!host_el0 && !kctl_el0_ten_i)
          v_o = '{res: RES_TRAP, sel: SEL_NONE,
                  tgt_el: (el2_en_i && tge_i) ? 2'd2 : 2'd1};
        else if (el2_en_i && !host_el2_i && !hctl_el1_pcen_i)
          v_o = '{res: RES_TRAP, sel: SEL_NONE, tgt_el: 2'd2};
        else if (host_el2_i && !tge_i && !hctl_el1_ten_i)
          v_o = '{res: RES_TRAP, sel: SEL_NONE, tgt_el: 2'd2};
        else if (host_el0 && !hctl_el0_ten_i)
          v_o = '{res: RES_TRAP, sel: SEL_NONE, tgt_el: 2'd2};
        else if (host_el0)
          v_o = '{res: RES_GRANT, sel: host_sel, tgt_el: 2'd0};
      end
      2'd1: begin
        if (el2_en_i && !host_el2_i && !hctl_el1_pcen_i)
          v_o = '{res: RES_TRAP, sel: SEL_NONE, tgt_el: 2'd2};
        else if (host_el2_i && !hctl_el1_ten_i)
          v_o = '{res: RES_TRAP, sel: SEL_NONE, tgt_el: 2'd2};
        else if (nv_i == 3'b111)
          v_o = '{res: RES_GRANT, sel: SEL_MEM, tgt_el: 2'd0};
      end
      2'd2: begin
        if (host_el2_i)
          v_o = '{res: RES_GRANT, sel: host_sel, tgt_el: 2'd0};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmrcmp_access_decoder.sv
module tmrcmp_access_decoder
  import tmrcmp_pkg::*;
#(
  parameter int SYND_W = 6,
  parameter int OFF_W  = 12,
  parameter logic [SYND_W-1:0] TRAP_CLASS = 6'h18,
  parameter logic [OFF_W-1:0]  MEM_OFFSET = 12'h178
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        enc_op0_i,
  input  logic [2:0]        enc_op1_i,
  input  logic [3:0]        enc_crn_i,
  input  logic [3:0]        enc_crm_i,
  input  logic [2:0]        enc_op2_i,
  input  logic              wr_i,
  input  logic [1:0]        el_i,
  input  logic              secure_i,
  input  logic              sel2_impl_i,
  input  logic              sel2_en_i,
  input  logic              el2_en_i,
  input  logic              host_el2_i,
  input  logic              tge_i,
  input  logic [2:0]        nv_i,
  input  logic              kctl_el0_ten_i,
  input  logic              hctl_el1_pcen_i,
  input  logic              hctl_el1_ten_i,
  input  logic              hctl_el0_ten_i,
  output logic [1:0]        res_o,
  output logic [2:0]        sel_o,
  output logic [1:0]        trap_el_o,
  output logic [SYND_W-1:0] trap_class_o,
  output logic [OFF_W-1:0]  mem_off_o,
  output logic              wr_o
);
  logic     sec_hit, alias_hit;
  verdict_t v_sec, v_alias, v_next, v_q;
  logic [SYND_W-1:0] class_q;
  logic [OFF_W-1:0]  off_q;
  logic              wr_q;

  tmrcmp_enc_match #(.OP0(2'd3), .OP1(3'd4), .CRN(4'd14), .CRM(4'd5), .OP2(3'd2)) sec_match_i (
    .op0_i(enc_op0_i), .op1_i(enc_op1_i), .crn_i(enc_crn_i),
    .crm_i(enc_crm_i), .op2_i(enc_op2_i), .hit_o(sec_hit));

  tmrcmp_enc_match #(.OP0(2'd3), .OP1(3'd3), .CRN(4'd14), .CRM(4'd2), .OP2(3'd2)) alias_match_i (
    .op0_i(enc_op0_i), .op1_i(enc_op1_i), .crn_i(enc_crn_i),
    .crm_i(enc_crm_i), .op2_i(enc_op2_i), .hit_o(alias_hit));

  tmrcmp_sechyp_rules sec_rules_i (
    .el_i(el_i), .secure_i(secure_i), .sel2_impl_i(sel2_impl_i),
    .sel2_en_i(sel2_en_i), .nv0_i(nv_i[0]), .v_o(v_sec));

  tmrcmp_alias_rules alias_rules_i (
    .el_i(el_i), .secure_i(secure_i), .sel2_impl_i(sel2_impl_i),
    .el2_en_i(el2_en_i), .host_el2_i(host_el2_i), .tge_i(tge_i), .nv_i(nv_i),
    .kctl_el0_ten_i(kctl_el0_ten_i), .hctl_el1_pcen_i(hctl_el1_pcen_i),
    .hctl_el1_ten_i(hctl_el1_ten_i), .hctl_el0_ten_i(hctl_el0_ten_i),
    .v_o(v_alias));

  always_comb begin
    if (sec_hit)        v_next = v_sec;
    else if (alias_hit) v_next = v_alias;
    else                v_next = '{res: RES_NOMATCH, sel: SEL_NONE, tgt_el: 2'd0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= '{res: RES_NOMATCH, sel: SEL_NONE, tgt_el: 2'd0};
      class_q <= '0;
      off_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      v_q     <= v_next;
      class_q <= (v_next.res == RES_TRAP) ? TRAP_CLASS : '0;
      off_q   <= (v_next.sel == SEL_MEM) ? MEM_OFFSET : '0;
      wr_q    <= wr_i;
    end
  end

  assign res_o        = v_q.res;
  assign sel_o        = v_q.sel;
  assign trap_el_o    = v_q.tgt_el;
  assign trap_class_o = class_q;
  assign mem_off_o    = off_q;
  assign wr_o         = wr_q;

  assert_nomatch_R1: assert property (@(posedge clk) disable iff (rst)
    (!sec_hit && !alias_hit) |=> (res_o == 2'd0 && sel_o == 3'd0));

  assert_sec_el0_undef_R2: assert property (@(posedge clk) disable iff (rst)
    (sec_hit && el_i == 2'd0) |=> (res_o == 2'd1));

  assert_alias_el3_R9: assert property (@(posedge clk) disable iff (rst)
    (alias_hit && el_i == 2'd3) |=> (res_o == 2'd3 && sel_o == 3'd3));

  assert_mem_offset_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_o == 3'd4) |-> (mem_off_o == MEM_OFFSET && res_o == 2'd3));

  assert_trap_class_R10: assert property (@(posedge clk) disable iff (rst)
    (res_o == 2'd2) |-> (trap_class_o == TRAP_CLASS && trap_el_o != 2'd0 && sel_o == 3'd0));

  assert_dir_echo_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wr_o == $past(wr_i)));
endmodule

// File: tb/tmrcmp_access_decoder_tb_top.sv
module tmrcmp_access_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0] op0; logic [2:0] op1; logic [3:0] crn, crm; logic [2:0] op2;
  logic wr; logic [1:0] el;
  logic secure, sel2_impl, sel2_en, el2_en, host, tge;
  logic [2:0] nv;
  logic k0, pcen, t1, t0;
  logic [1:0] res; logic [2:0] sel; logic [1:0] tel;
  logic [5:0] cls; logic [11:0] off; logic wro;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  tmrcmp_access_decoder dut_i (
    .clk(clk), .rst(rst),
    .enc_op0_i(op0), .enc_op1_i(op1), .enc_crn_i(crn), .enc_crm_i(crm), .enc_op2_i(op2),
    .wr_i(wr), .el_i(el), .secure_i(secure), .sel2_impl_i(sel2_impl), .sel2_en_i(sel2_en),
    .el2_en_i(el2_en), .host_el2_i(host), .tge_i(tge), .nv_i(nv),
    .kctl_el0_ten_i(k0), .hctl_el1_pcen_i(pcen), .hctl_el1_ten_i(t1), .hctl_el0_ten_i(t0),
    .res_o(res), .sel_o(sel), .trap_el_o(tel), .trap_class_o(cls), .mem_off_o(off), .wr_o(wro));

  // Expected verdict {res, sel, trap level} from the requirements; which: 0 none, 1 secure hyp, 2 alias
  function automatic logic [6:0] model(int which);
    logic h0;
    logic [2:0] hs;
    h0 = host & tge;
    hs = (secure && sel2_impl) ? 3'd1 : (!secure ? 3'd2 : 3'd3);
    if (which == 0) return {2'd0, 3'd0, 2'd0};
    if (which == 1) begin
      if (!sel2_impl || el == 2'd0) return {2'd1, 3'd0, 2'd0};
      if (el == 2'd1) return (secure && nv[0]) ? {2'd2, 3'd0, 2'd2} : {2'd1, 3'd0, 2'd0};
      if (el == 2'd2) return secure ? {2'd3, 3'd1, 2'd0} : {2'd1, 3'd0, 2'd0};
      return sel2_en ? {2'd3, 3'd1, 2'd0} : {2'd1, 3'd0, 2'd0};
    end
    case (el)
      2'd0: begin
        if (!h0 && !k0) return {2'd2, 3'd0, (el2_en && tge) ? 2'd2 : 2'd1};
        if (el2_en && !host && !pcen) return {2'd2, 3'd0, 2'd2};
        if (host && !tge && !t1) return {2'd2, 3'd0, 2'd2};
        if (h0 && !t0) return {2'd2, 3'd0, 2'd2};
        return {2'd3, h0 ? hs : 3'd3, 2'd0};
      end
      2'd1: begin
        if (el2_en && !host && !pcen) return {2'd2, 3'd0, 2'd2};
        if (host && !t1) return {2'd2, 3'd0, 2'd2};
        return {2'd3, (nv == 3'b111) ? 3'd4 : 3'd3, 2'd0};
      end
      2'd2: return {2'd3, host ? hs : 3'd3, 2'd0};
      default: return {2'd3, 3'd3, 2'd0};
    endcase
  endfunction

  function automatic string tag_of(int which);
    if (which == 0) return "R1";
    if (which == 1) begin
      if (!sel2_impl || el == 2'd0) return "R2";
      if (el == 2'd1) return "R3";
      return "R4";
    end
    case (el)
      2'd0: return "R5/R6";
      2'd1: return "R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic set_enc(int which);
    op0 = 2'd3; crn = 4'd14; op2 = 3'd2;
    if (which == 1) begin op1 = 3'd4; crm = 4'd5; end
    else            begin op1 = 3'd3; crm = 4'd2; end
  endtask

  task automatic set_ctrl(logic [14:0] v);
    el = v[1:0]; secure = v[2]; sel2_impl = v[3]; sel2_en = v[4]; el2_en = v[5];
    host = v[6]; tge = v[7]; nv = v[10:8]; k0 = v[11]; pcen = v[12]; t1 = v[13]; t0 = v[14];
  endtask

  // Sampled one clock after the inputs were set (one register stage, R10)
  task automatic check(int which, logic wexp, string tag);
    logic [6:0] e;
    logic [5:0] ecls;
    logic [11:0] eoff;
    e = model(which);
    ecls = (e[6:5] == 2'd2) ? 6'h18 : 6'h00;
    eoff = (e[4:2] == 3'd4) ? 12'h178 : 12'h000;
    n_tests++;
    if ({res, sel, tel} !== e || cls !== ecls || off !== eoff || wro !== wexp) begin
      n_fail++;
      $display("FAIL %s (R10|R11 fields): res=%0d sel=%0d el=%0d cls=%h off=%h wr=%b exp res=%0d sel=%0d el=%0d cls=%h off=%h wr=%b",
               tag, res, sel, tel, cls, off, wro, e[6:5], e[4:2], e[1:0], ecls, eoff, wexp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected < 200000", cycles);
      finish_run();
    end
  end

  initial begin
    set_enc(2); set_ctrl(15'h7fff); wr = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state while reset is held
    n_tests++;
    if (res !== 2'd0 || sel !== 3'd0 || tel !== 2'd0 || cls !== 6'd0 || off !== 12'd0 || wro !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset: res=%0d sel=%0d el=%0d cls=%h off=%h wr=%b expected all zero",
               res, sel, tel, cls, off, wro);
    end
    rst = 1'b0;

    // Exhaustive control sweep for both recognised encodings, direction = parity (R11)
    for (int w = 1; w <= 2; w++) begin
      for (int v = 0; v < 32768; v++) begin
        set_enc(w); set_ctrl(v[14:0]); wr = ^v[14:0];
        @(negedge clk);
        check(w, ^v[14:0], tag_of(w));
      end
    end

    // R11: the same controls with both directions give the same verdict
    for (int d = 0; d < 2; d++) begin
      set_enc(2); set_ctrl(15'h0701); wr = d[0];
      @(negedge clk);
      check(2, d[0], "R11");
    end

    // R1: encodings one field away from a match
    set_ctrl(15'h7fff);
    for (int k = 0; k < 6; k++) begin
      set_enc(k % 2 + 1); wr = 1'b0;
      case (k)
        0: op0 = 2'd2;
        1: op1 = 3'd5;
        2: crn = 4'd13;
        3: crm = 4'd4;
        4: op2 = 3'd1;
        default: begin op1 = 3'd3; crm = 4'd5; end
      endcase
      @(negedge clk);
      check(0, 1'b0, "R1");
    end

    done = 1'b1;
    finish_run();
  end
endmodule